// File: doc/BRIEF.md
# Error Sample FIFO Register Port

This block is a byte-wide register port on the management side of a repeater-style device. A host talks to it through single-cycle accesses. Each access has a command/data select (`acc_cd`) and a direction (`acc_wr`). A write with the select high goes to the command register. The first such write picks a register bank. The next one picks a register address inside that bank. After that, the command register expects a bank again. Accesses with the select low read or write the register chosen this way. The choice stays in place, so repeated data reads hit the same register.

The management bank (bank 7) holds two registers and a status register:
- an 8-bit device ID register that can be read and written;
- a window onto an error-sample FIFO;
- a status register with a sticky overflow bit.

Error records arrive from elsewhere on a 64-bit parallel push interface. The FIFO keeps up to four of them. The host drains the oldest record with eight data reads, one byte per read, least significant byte first. The host can give up on a record partway through by issuing any command write. The rest of that record is then discarded and the next record is presented from its first byte.

Top module: `errsamp_regport`

## Requirements
- R1: After reset, bank 0 is selected, the command register expects a bank number, the device ID is 0x00, the FIFO is empty, the byte pointer is zero and the overflow flag is clear. A data read in bank 0 returns 0x00.
- R2: Command writes alternate between bank and address, starting with a bank. Data reads and writes leave the bank and the address unchanged.
- R3: In bank 7, address 0xE0 is the device ID register. A data write there stores the byte, and a data read returns it. Data writes to any other bank or address leave the ID unchanged.
- R4: In bank 7, address 0xE2 returns the oldest record one byte per data read. The first read gives bits 7:0, the eighth gives bits 63:56. The eighth read removes the record, and records leave in arrival order.
- R5: A data read at 0xE2 while the FIFO is empty returns 0x00 and changes neither the byte pointer nor the FIFO.
- R6: A command write while a record is partly read drops the rest of that record. The next read at 0xE2 returns byte 0 of the following record. A command write with the byte pointer at zero removes nothing.
- R7: The FIFO holds four records. A push while it is full, with no removal in the same cycle, is dropped. It also sets a sticky overflow flag that reads as bit 0 of bank 7 address 0xE3 (other bits 0). Only reset clears the flag.
- R8: A push and a removal in the same cycle both take effect. If the FIFO is full at the time, the push is accepted and the overflow flag is not set.
- R9: A data read of any register other than bank 7 addresses 0xE0, 0xE2 and 0xE3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_cd | input | 1 | 1: command register, 0: data register |
| acc_wr | input | 1 | 1: write, 0: read |
| acc_wdata | input | 8 | Host write byte |
| acc_rdata | output | 8 | Read byte for the current access (combinational) |
| rec_valid | input | 1 | Push strobe for an error record |
| rec_data | input | 64 | Error record pushed with `rec_valid` |

## Verification
Two functions can land in the same cycle: a record push and the removal of the head record. The removal comes either from the eighth byte read or from a skipping command write. The bench provokes this by pulsing `rec_valid` in the same cycle as the final byte read of a record, both with the FIFO partly filled and with it full. It also does this in the same cycle as a mid-record command write. The results are judged by draining the FIFO afterwards. The scoreboard expects the pushed record to appear last with all eight bytes intact. It also expects the overflow bit to change only when a push meets a full FIFO with nothing leaving.

// File: rtl/errsamp_pkg.sv
package errsamp_pkg;
  localparam int BYTE_W    = 8;
  localparam int REC_BYTES = 8;
  localparam int REC_W     = BYTE_W * REC_BYTES;
  localparam int BPTR_W    = $clog2(REC_BYTES);

  localparam logic [BYTE_W-1:0] MGMT_BANK = 8'h07;
  localparam logic [BYTE_W-1:0] ID_ADDR   = 8'hE0;
  localparam logic [BYTE_W-1:0] FIFO_ADDR = 8'hE2;
  localparam logic [BYTE_W-1:0] STAT_ADDR = 8'hE3;

  // byte idx of a record, index 0 is the least significant byte
  function automatic logic [BYTE_W-1:0] rec_byte(input logic [REC_W-1:0] rec,
                                                 input logic [BPTR_W-1:0] idx);
    return rec[idx*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic is_last_byte(input logic [BPTR_W-1:0] idx);
    return idx == BPTR_W'(REC_BYTES - 1);
  endfunction
endpackage

// File: rtl/errsamp_cmdreg.sv
module errsamp_cmdreg
  import errsamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] bank,
  output logic [BYTE_W-1:0] addr
);
  logic want_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank      <= '0;
      addr      <= '0;
      want_addr <= 1'b0;
    end else if (cmd_wr) begin
      if (want_addr) addr <= wdata;
      else           bank <= wdata;
      want_addr <= ~want_addr;
    end
  end
endmodule

// File: rtl/errsamp_fifo.sv
module errsamp_fifo
  import errsamp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [REC_W-1:0] din,
  input  logic             pop,
  output logic [REC_W-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             push_acc,
  output logic [CW-1:0]    count,
  output logic             ovf
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_ok   = pop && !empty;
  assign push_acc = push && (!full || pop_ok);
  assign head     = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_acc) begin
        mem[wptr] <= din;
        wptr      <= bump(wptr);
      end
      if (pop_ok) rptr <= bump(rptr);
      if (push_acc && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_acc) count <= count - CW'(1);
      if (push && !push_acc) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/errsamp_bytesel.sv
module errsamp_bytesel
  import errsamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              skip_req,
  input  logic              has_data,
  input  logic [REC_W-1:0]  head,
  output logic [BYTE_W-1:0] byte_out,
  output logic [BPTR_W-1:0] bptr,
  output logic              pop
);
  logic rd_pop, skip_pop;

  assign rd_pop   = rd_evt && has_data && is_last_byte(bptr);
  assign skip_pop = skip_req && has_data && (bptr != '0);
  assign pop      = rd_pop || skip_pop;
  assign byte_out = has_data ? rec_byte(head, bptr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                   bptr <= '0;
    else if (pop)                 bptr <= '0;
    else if (rd_evt && has_data)  bptr <= bptr + BPTR_W'(1);
  end
endmodule

// File: rtl/errsamp_regport.sv
module errsamp_regport
  import errsamp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_cd,
  input  logic              acc_wr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  input  logic              rec_valid,
  input  logic [REC_W-1:0]  rec_data
);
  logic [BYTE_W-1:0] bank, addr, dev_id, fifo_byte;
  logic [REC_W-1:0]  head;
  logic [BPTR_W-1:0] bptr;
  logic [CW-1:0]     count;
  logic empty, full, push_acc, ovf, pop;

  // named access events
  logic cmd_wr, dat_rd, dat_wr, in_mgmt, sel_id, sel_fifo, sel_stat;
  logic id_wr, fifo_rd_evt, empty_rd, skip_evt;

  assign cmd_wr      = acc_en &&  acc_cd &&  acc_wr;
  assign dat_rd      = acc_en && !acc_cd && !acc_wr;
  assign dat_wr      = acc_en && !acc_cd &&  acc_wr;
  assign in_mgmt     = (bank == MGMT_BANK);
  assign sel_id      = in_mgmt && (addr == ID_ADDR);
  assign sel_fifo    = in_mgmt && (addr == FIFO_ADDR);
  assign sel_stat    = in_mgmt && (addr == STAT_ADDR);
  assign id_wr       = dat_wr && sel_id;
  assign fifo_rd_evt = dat_rd && sel_fifo && !empty;
  assign empty_rd    = dat_rd && sel_fifo && empty;
  assign skip_evt    = cmd_wr && pop;

  errsamp_cmdreg u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(acc_wdata),
    .bank(bank), .addr(addr)
  );

  errsamp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rec_valid), .din(rec_data), .pop(pop),
    .head(head), .empty(empty), .full(full), .push_acc(push_acc),
    .count(count), .ovf(ovf)
  );

  errsamp_bytesel u_sel (
    .clk(clk), .rst_n(rst_n), .rd_evt(fifo_rd_evt), .skip_req(cmd_wr),
    .has_data(!empty), .head(head), .byte_out(fifo_byte), .bptr(bptr),
    .pop(pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     dev_id <= '0;
    else if (id_wr) dev_id <= acc_wdata;
  end

  always_comb begin
    acc_rdata = '0;
    if (sel_id)        acc_rdata = dev_id;
    else if (sel_fifo) acc_rdata = fifo_byte;
    else if (sel_stat) acc_rdata = {{(BYTE_W-1){1'b0}}, ovf};
  end
endmodule

// File: rtl/errsamp_regport_chk.sv
module errsamp_regport_chk
  import errsamp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              dat_rd,
  input logic              id_wr,
  input logic              fifo_rd_evt,
  input logic              empty_rd,
  input logic              skip_evt,
  input logic              rec_valid,
  input logic              full,
  input logic              pop,
  input logic              push_acc,
  input logic              ovf,
  input logic [CW-1:0]     count,
  input logic [BPTR_W-1:0] bptr,
  input logic [BYTE_W-1:0] dev_id,
  input logic [BYTE_W-1:0] bank,
  input logic [BYTE_W-1:0] addr
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && full && !pop) |=> ovf);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_rd |=> ($stable(bptr) && $stable(count)));
  assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_evt && !pop) |=> (bptr == $past(bptr) + BPTR_W'(1)));
  assert_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_evt && !rec_valid) |=> (bptr == '0 && count == $past(count) - CW'(1)));
  assert_push_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push_acc) |=> $stable(count));
  assert_full_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && full && pop) |=> (count == CW'(DEPTH) && $stable(ovf)));
  assert_id_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(dev_id));
  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && dat_rd) |=> ($stable(bank) && $stable(addr)));
endmodule

bind errsamp_regport errsamp_regport_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_rd(dat_rd), .id_wr(id_wr),
  .fifo_rd_evt(fifo_rd_evt), .empty_rd(empty_rd), .skip_evt(skip_evt),
  .rec_valid(rec_valid), .full(full), .pop(pop), .push_acc(push_acc),
  .ovf(ovf), .count(count), .bptr(bptr), .dev_id(dev_id), .bank(bank),
  .addr(addr)
);

// File: tb/errsamp_regport_test.sv
module errsamp_regport_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_cd = 1'b0, acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        rec_valid = 1'b0;
  logic [63:0] rec_data = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // scoreboard
  logic [7:0] expq[$];
  string      tagq[$];

  // bench-side model
  logic [63:0] recq[$];
  int          mptr = 0;
  bit          mphase = 0, movf = 0;
  logic [7:0]  mbank = 0, maddr = 0, mid = 0;

  always #5 clk = ~clk;

  errsamp_regport uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_cd(acc_cd),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rec_valid(rec_valid), .rec_data(rec_data)
  );

  function automatic logic [7:0] model_rd();
    if (mbank != 8'h07) return 8'h00;
    if (maddr == 8'hE0) return mid;
    if (maddr == 8'hE2) return (recq.size() > 0) ? recq[0][mptr*8 +: 8] : 8'h00;
    if (maddr == 8'hE3) return {7'b0, movf};
    return 8'h00;
  endfunction

  // monitor: compare read data mid-cycle
  always @(negedge clk) begin
    if (rst_n && acc_en && !acc_wr && expq.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (acc_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, acc_rdata, e);
      end
    end
  end

  // one host cycle, optionally with a record push
  task automatic step(input bit en, input bit cd, input bit wr, input logic [7:0] wd,
                      input bit pv, input logic [63:0] pd, input string tag);
    bit popped = 0;
    @(posedge clk); #1;
    acc_en = en; acc_cd = cd; acc_wr = wr; acc_wdata = wd;
    rec_valid = pv; rec_data = pd;
    if (en && cd && wr) begin
      if (mptr != 0 && recq.size() > 0) popped = 1;
      mptr = popped ? 0 : mptr;
      if (!mphase) mbank = wd; else maddr = wd;
      mphase = !mphase;
    end else if (en && !cd && wr) begin
      if (mbank == 8'h07 && maddr == 8'hE0) mid = wd;
    end else if (en && !cd && !wr) begin
      expq.push_back(model_rd());
      tagq.push_back(tag);
      if (mbank == 8'h07 && maddr == 8'hE2 && recq.size() > 0) begin
        if (mptr == 7) begin popped = 1; mptr = 0; end
        else mptr++;
      end
    end
    if (popped) void'(recq.pop_front());
    if (pv) begin
      if (recq.size() < 4) recq.push_back(pd);
      else movf = 1;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 8'h00, 0, '0, "");
  endtask
  task automatic cmd(input logic [7:0] v);
    step(1, 1, 1, v, 0, '0, "");
  endtask
  task automatic sel(input logic [7:0] b, input logic [7:0] a);
    cmd(b); cmd(a);
  endtask
  task automatic dwr(input logic [7:0] v);
    step(1, 0, 1, v, 0, '0, "");
  endtask
  task automatic drd(input string tag);
    step(1, 0, 0, 8'h00, 0, '0, tag);
  endtask
  task automatic push(input logic [63:0] r);
    step(0, 0, 0, 8'h00, 1, r, "");
  endtask
  task automatic drain_one(input string tag);
    for (int i = 0; i < 8; i++) drd(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    drd("R1 bank0 read");
    sel(8'h07, 8'hE0); drd("R1 id reset");
    sel(8'h07, 8'hE2); drd("R1 fifo empty");
    sel(8'h07, 8'hE3); drd("R1 ovf clear");

    // R3 / R2: device ID and sticky selection
    sel(8'h07, 8'hE0); dwr(8'h5A);
    drd("R3 id readback"); drd("R2 selection held"); drd("R2 selection held");
    sel(8'h03, 8'hE0); dwr(8'hFF); drd("R9 other bank");
    sel(8'h07, 8'hE1); dwr(8'h11); drd("R9 other addr");
    sel(8'h07, 8'hE0); drd("R3 id untouched");

    // R5: empty reads
    sel(8'h07, 8'hE2); drd("R5 empty"); drd("R5 empty");
    push(64'h8877_6655_4433_2211);
    drain_one("R4 byte order");
    drd("R5 empty after drain");

    // R6: skip mid-record
    push(64'hB7B6_B5B4_B3B2_B1B0);
    push(64'hC7C6_C5C4_C3C2_C1C0);
    drd("R4 partial"); drd("R4 partial"); drd("R4 partial");
    sel(8'h07, 8'hE2);
    drain_one("R6 next after skip");
    drd("R6 empty after");

    // R7: overflow
    push(64'hD7D6_D5D4_D3D2_D1D0);
    push(64'hE7E6_E5E4_E3E2_E1E0);
    push(64'hF7F6_F5F4_F3F2_F1F0);
    push(64'h0706_0504_0302_0100);
    sel(8'h07, 8'hE3); drd("R7 no ovf at four");
    push(64'hDEAD_BEEF_DEAD_BEEF);
    drd("R7 ovf set");
    sel(8'h07, 8'hE2);
    for (int k = 0; k < 4; k++) drain_one("R7 kept four");
    drd("R7 dropped record absent");

    // R8: push with removal, not full
    push(64'h1717_1616_1515_1414);
    for (int i = 0; i < 7; i++) drd("R8 bytes");
    step(1, 0, 0, 8'h00, 1, 64'h2727_2626_2525_2424, "R8 last byte");
    drain_one("R8 pushed during pop");
    // R8: push during removal when full
    push(64'h3131_3131_3131_3130); push(64'h3232_3232_3232_3231);
    push(64'h3333_3333_3333_3332); push(64'h3434_3434_3434_3433);
    for (int i = 0; i < 7; i++) drd("R8 full bytes");
    step(1, 0, 0, 8'h00, 1, 64'h4545_4545_4545_4544, "R8 full last byte");
    // R8: push during a skip
    drd("R8 partial");
    step(1, 1, 1, 8'h07, 1, 64'h5656_5656_5656_5655, "");
    cmd(8'hE2);
    for (int k = 0; k < 4; k++) drain_one("R8 drain order");
    drd("R8 empty at end");
    sel(8'h07, 8'hE3); drd("R7 ovf still sticky");
    idle(); idle();

    if (expq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d left expected=0", expq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule